// File: doc/BRIEF.md
# Health Monitor Interrupt Aggregator

This block gathers every interrupt source of a hardware health monitor and drives a single active-low interrupt line. It does no measuring itself: the measurement engine hands it one-cycle strobes for analog/temperature limit violations, fan tachometer counts, and the pulses that mark the start of each analog or fan monitoring cycle. Sensing pins such as GPIOs and the chassis-intrusion switch are wired straight in. The only other input is the automatic fan controller's start/stop event.

There are three classes of source.

- **Latched sources.** The analog class and the fan-underspeed class each keep sticky status bits and their own interrupt latch. Once an interrupt has been cleared, a class stays silent until the next cycle-start pulse for that same class.
- **Level sources.** GPIO pins (with programmable polarity) and chassis intrusion are not latched. They hold the interrupt for as long as they are active and unmasked.
- **One-shot source.** The fan-control event raises a single interrupt that lasts until it is cleared or until the next analog cycle begins.

Software sees a small register space with a configuration word, masks, GPIO polarity and fan limits. It also sees status words. Reading the primary (analog) status word clears all latched status. An alert-response acknowledge from the bus side acts as a further clear.

Top module: `hwmon_irq_ctrl`

## Requirements
- R1: After reset, `int_n` is 1. All status words read 0 while inputs are idle. CFG (address 0), all masks (addresses 5 to 8) and `rd_data` are 0. Polarity words (address 9 = GPIO 0..7, address 10 bit 0 = GPIO 8) reset to all ones. Fan limit words (address 16+i) reset to all ones.
- R2: `int_n` is low only while CFG bit 1 (enable) is 1 and CFG bit 2 (clear) is 0. `int_n` is a register that follows the internal source state one clock later.
- R3: An `ana_set` strobe sets the matching bits of the analog status word (address 1). If an unmasked strobe bit arrives while the analog class is armed, the analog latch sets on that edge and `int_n` falls on the following edge.
- R4: A fan measurement (`fan_meas_vld`) whose count is strictly greater than the limit of fan `fan_meas_idx` sets bit idx of the fan status word (address 2). A count equal to or below the limit sets nothing. Fan bits are sticky, and an unmasked one sets the fan latch while that class is armed.
- R5: A read of address 1 returns the status as it was before the read. It then clears the analog word, the fan word and misc bit 4. GPIO and intrusion status (address 3, misc bits 6 and 7) are unaffected.
- R6: Each of three clear events drops the analog latch, the fan latch and the fan-control one-shot, so that `int_n` returns high one edge later. The clear events are a read of address 1, CFG bit 2 at 1, and an `alert_resp_hit` pulse. The acknowledge leaves the status words unchanged.
- R7: After a clear event, a latched class disarms. It cannot set its latch again until its own cycle-start pulse arrives (`ana_cycle_start` or `fan_cycle_start`). The other class's pulse does not re-arm it.
- R8: The GPIO status bit i is `gpio_in[i]` when its polarity bit is 1 and the inverse of `gpio_in[i]` when its polarity bit is 0. GPIO 0..7 appear in address 3, GPIO 8 appears in misc (address 4) bit 7, and `intrusion` (active high) appears in misc bit 6. These bits are never latched, ignore all clear events, and hold `int_n` low while active and unmasked.
- R9: A mask bit at 1 keeps its status bit from affecting `int_n`. The status bit still records the event. The misc mask (address 8) uses the same bit positions as the misc status word.
- R10: With CFG bit 3 at 1, an `afc_event` sets misc bit 4 and, unless that bit is masked, a one-shot interrupt. With CFG bit 3 at 0, the event does nothing. `ana_cycle_start` clears both misc bit 4 and the one-shot. A cleared one-shot never comes back on its own.
- R11: Registers written through `wr_en`/`wr_addr`/`wr_data` read back unchanged at the same address. `rd_data` is loaded on the edge at which `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | DW | Read data, registered |
| ana_set | input | DW | Analog out-of-limit strobes, one per channel |
| ana_cycle_start | input | 1 | Start of analog monitoring cycle |
| fan_meas_vld | input | 1 | Fan count valid strobe |
| fan_meas_idx | input | $clog2(NUM_FAN) | Fan being reported |
| fan_meas_cnt | input | DW | Measured fan count |
| fan_cycle_start | input | 1 | Start of fan monitoring cycle |
| gpio_in | input | DW+1 | GPIO pin levels |
| intrusion | input | 1 | Chassis intrusion level, active high |
| afc_event | input | 1 | Fan-control start/stop pulse |
| alert_resp_hit | input | 1 | Alert-response address acknowledged |
| int_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with DW = 8 and NUM_FAN = 8. That gives a full eight-fan status word and a three-bit fan index, so random measurements reach every fan limit, including counts that exactly equal a limit. With nine GPIOs, the last pin lands in the misc word beside the intrusion bit. This lets random polarity and mask patterns cover both the split status layout and the shared misc mask. Directed sequences cover the arming rules, where a clear is followed by a cycle-start pulse of the wrong class and then of the right class.

// File: rtl/hwmon_irq_pkg.sv
// Package: shared register addresses and bit positions for the
// health-monitor interrupt aggregator.
// Assumes a 5-bit register address space.
package hwmon_irq_pkg;

    localparam int RA_W = 5;

    localparam logic [RA_W-1:0] A_CFG     = 5'd0;
    localparam logic [RA_W-1:0] A_ST_ANA  = 5'd1;   // primary status, read clears
    localparam logic [RA_W-1:0] A_ST_FAN  = 5'd2;
    localparam logic [RA_W-1:0] A_ST_GPIO = 5'd3;
    localparam logic [RA_W-1:0] A_ST_MISC = 5'd4;
    localparam logic [RA_W-1:0] A_MK_ANA  = 5'd5;
    localparam logic [RA_W-1:0] A_MK_FAN  = 5'd6;
    localparam logic [RA_W-1:0] A_MK_GPIO = 5'd7;
    localparam logic [RA_W-1:0] A_MK_MISC = 5'd8;
    localparam logic [RA_W-1:0] A_POL_LO  = 5'd9;
    localparam logic [RA_W-1:0] A_POL_HI  = 5'd10;
    localparam logic [RA_W-1:0] A_FAN_LIM = 5'd16;  // 16 + fan index

    localparam int CFG_EN  = 1;
    localparam int CFG_CLR = 2;
    localparam int CFG_AFC = 3;

    localparam int MISC_AFC   = 4;
    localparam int MISC_INTR  = 6;
    localparam int MISC_GLAST = 7;

endpackage

// File: rtl/hwmon_irq_regs.sv
// Module: software-writable configuration.
// Holds CFG, the four masks, the GPIO polarity and one limit per fan.
// Assumes NUM_FAN <= 16 so that all limits fit above A_FAN_LIM.
module hwmon_irq_regs
    import hwmon_irq_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NUM_FAN = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [RA_W-1:0]               wr_addr,
    input  logic [DW-1:0]                 wr_data,
    output logic [DW-1:0]                 cfg_q,
    output logic [DW-1:0]                 mask_ana,
    output logic [DW-1:0]                 mask_fan,
    output logic [DW-1:0]                 mask_gpio,
    output logic [DW-1:0]                 mask_misc,
    output logic [DW-1:0]                 pol_lo,
    output logic                          pol_hi,
    output logic [NUM_FAN-1:0][DW-1:0]    fan_lim
);

    // Purpose: load the control words on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            mask_ana  <= '0;
            mask_fan  <= '0;
            mask_gpio <= '0;
            mask_misc <= '0;
            pol_lo    <= '1;
            pol_hi    <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG:     cfg_q     <= wr_data;
                A_MK_ANA:  mask_ana  <= wr_data;
                A_MK_FAN:  mask_fan  <= wr_data;
                A_MK_GPIO: mask_gpio <= wr_data;
                A_MK_MISC: mask_misc <= wr_data;
                A_POL_LO:  pol_lo    <= wr_data;
                A_POL_HI:  pol_hi    <= wr_data[0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_FAN; g++) begin : g_lim
        // Purpose: per-fan underspeed limit, resets to the maximum count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fan_lim[g] <= '1;
            else if (wr_en && wr_addr == (A_FAN_LIM + RA_W'(g)))
                fan_lim[g] <= wr_data;
        end
    end

endmodule

// File: rtl/hwmon_irq_fancmp.sv
// Module: turns one fan measurement into a one-hot underspeed strobe.
// A count strictly above the selected limit flags that fan.
// Assumes that an index at or beyond NUM_FAN flags nothing.
module hwmon_irq_fancmp #(
    parameter int DW      = 8,
    parameter int NUM_FAN = 8,
    localparam int FIDX_W = (NUM_FAN > 1) ? $clog2(NUM_FAN) : 1
) (
    input  logic                       meas_vld,
    input  logic [FIDX_W-1:0]          meas_idx,
    input  logic [DW-1:0]              meas_cnt,
    input  logic [NUM_FAN-1:0][DW-1:0] lim,
    output logic [NUM_FAN-1:0]         set_vec
);

    for (genvar g = 0; g < NUM_FAN; g++) begin : g_cmp
        // Purpose: flag fan g when it is reported slower than its limit.
        always_comb
            set_vec[g] = meas_vld && (meas_idx == FIDX_W'(g)) && (meas_cnt > lim[g]);
    end

endmodule

// File: rtl/hwmon_irq_class.sv
// Module: one latched interrupt class (analog or fan).
// Keeps sticky status bits, an interrupt latch and an arm flag.
// A clear drops the latch and disarms the class. Only this class's
// cycle-start pulse re-arms it.
// Assumes set strobes take priority over a same-cycle status clear.
module hwmon_irq_class #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] mask,
    input  logic         cyc_start,
    input  logic         clr_stat,
    input  logic         clr_irq,
    output logic [W-1:0] stat,
    output logic         irq
);

    logic armed;
    logic hit;

    // Purpose: an unmasked event arriving in this cycle.
    always_comb hit = |(set_vec & ~mask);

    // Purpose: sticky status, cleared by a read of the primary word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= (clr_stat ? '0 : stat) | set_vec;
    end

    // Purpose: arm flag; a clear disarms, a cycle start re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (clr_irq)
            armed <= 1'b0;
        else if (cyc_start)
            armed <= 1'b1;
    end

    // Purpose: interrupt latch of this class.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (clr_irq)
            irq <= 1'b0;
        else if (armed && hit)
            irq <= 1'b1;
    end

    p_clear_drops_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq |=> !irq);

    p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !irq && !cyc_start) |=> !irq);

    p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((stat & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/hwmon_irq_level.sv
// Module: unlatched level sources.
// Applies polarity to the GPIOs, adds chassis intrusion and
// reports whether any active, unmasked level source exists.
// Purely combinational; nothing here can be cleared.
module hwmon_irq_level #(
    parameter int DW = 8,
    localparam int NG = DW + 1
) (
    input  logic [NG-1:0] gpio_in,
    input  logic [DW-1:0] pol_lo,
    input  logic          pol_hi,
    input  logic          intrusion,
    input  logic [DW-1:0] mask_gpio,
    input  logic          mask_glast,
    input  logic          mask_intr,
    output logic [DW-1:0] gpio_stat,
    output logic          glast_stat,
    output logic          intr_stat,
    output logic          level_any
);

    logic [NG-1:0] pol;

    // Purpose: join both polarity words into one vector.
    always_comb pol = {pol_hi, pol_lo};

    for (genvar g = 0; g < DW; g++) begin : g_pol
        // Purpose: active when the pin matches its polarity bit.
        always_comb gpio_stat[g] = gpio_in[g] ^ ~pol[g];
    end

    // Purpose: the last GPIO and the intrusion level.
    always_comb begin
        glast_stat = gpio_in[NG-1] ^ ~pol[NG-1];
        intr_stat  = intrusion;
    end

    // Purpose: any active level source that its mask lets through.
    always_comb
        level_any = (|(gpio_stat & ~mask_gpio)) | (glast_stat & ~mask_glast)
                  | (intr_stat & ~mask_intr);

endmodule

// File: rtl/hwmon_irq_ctrl.sv
// Module: top of the health-monitor interrupt aggregator.
// Combines the two latched classes, the level sources and the
// fan-control one-shot into the registered active-low interrupt.
// Also decodes clear events and serves register reads.
// Assumes DW >= 8 so that the misc word holds bits 4, 6 and 7.
module hwmon_irq_ctrl
    import hwmon_irq_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NUM_FAN = 8,
    localparam int FIDX_W = (NUM_FAN > 1) ? $clog2(NUM_FAN) : 1,
    localparam int NG     = DW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     ana_set,
    input  logic              ana_cycle_start,
    input  logic              fan_meas_vld,
    input  logic [FIDX_W-1:0] fan_meas_idx,
    input  logic [DW-1:0]     fan_meas_cnt,
    input  logic              fan_cycle_start,
    input  logic [NG-1:0]     gpio_in,
    input  logic              intrusion,
    input  logic              afc_event,
    input  logic              alert_resp_hit,
    output logic              int_n
);

    logic [DW-1:0]              cfg_q, mask_ana, mask_fan, mask_gpio, mask_misc, pol_lo;
    logic                       pol_hi;
    logic [NUM_FAN-1:0][DW-1:0] fan_lim;
    logic [NUM_FAN-1:0]         fan_set, fan_stat;
    logic [DW-1:0]              ana_stat, gpio_stat, misc_stat, rd_mux;
    logic                       ana_irq, fan_irq, afc_irq, afc_stat;
    logic                       glast_stat, intr_stat, level_any;
    logic                       rd_clear, clr_evt, afc_ev, int_on;

    hwmon_irq_regs #(.DW(DW), .NUM_FAN(NUM_FAN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_q(cfg_q), .mask_ana(mask_ana), .mask_fan(mask_fan), .mask_gpio(mask_gpio),
        .mask_misc(mask_misc), .pol_lo(pol_lo), .pol_hi(pol_hi), .fan_lim(fan_lim)
    );

    hwmon_irq_fancmp #(.DW(DW), .NUM_FAN(NUM_FAN)) u_fancmp (
        .meas_vld(fan_meas_vld), .meas_idx(fan_meas_idx), .meas_cnt(fan_meas_cnt),
        .lim(fan_lim), .set_vec(fan_set)
    );

    // Purpose: decode the status-clearing read and the three clear events.
    always_comb begin
        rd_clear = rd_en && (rd_addr == A_ST_ANA);
        clr_evt  = rd_clear || cfg_q[CFG_CLR] || alert_resp_hit;
        afc_ev   = afc_event && cfg_q[CFG_AFC];
    end

    hwmon_irq_class #(.W(DW)) u_ana (
        .clk(clk), .rst_n(rst_n), .set_vec(ana_set), .mask(mask_ana),
        .cyc_start(ana_cycle_start), .clr_stat(rd_clear), .clr_irq(clr_evt),
        .stat(ana_stat), .irq(ana_irq)
    );

    hwmon_irq_class #(.W(NUM_FAN)) u_fan (
        .clk(clk), .rst_n(rst_n), .set_vec(fan_set), .mask(mask_fan[NUM_FAN-1:0]),
        .cyc_start(fan_cycle_start), .clr_stat(rd_clear), .clr_irq(clr_evt),
        .stat(fan_stat), .irq(fan_irq)
    );

    hwmon_irq_level #(.DW(DW)) u_level (
        .gpio_in(gpio_in), .pol_lo(pol_lo), .pol_hi(pol_hi), .intrusion(intrusion),
        .mask_gpio(mask_gpio), .mask_glast(mask_misc[MISC_GLAST]),
        .mask_intr(mask_misc[MISC_INTR]), .gpio_stat(gpio_stat),
        .glast_stat(glast_stat), .intr_stat(intr_stat), .level_any(level_any)
    );

    // Purpose: fan-control status bit, cleared by analog cycle start or primary read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            afc_stat <= 1'b0;
        else
            afc_stat <= (afc_stat & ~(ana_cycle_start | rd_clear)) | afc_ev;
    end

    // Purpose: fan-control one-shot interrupt; a clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n)
            afc_irq <= 1'b0;
        else if (clr_evt)
            afc_irq <= 1'b0;
        else if (afc_ev && !mask_misc[MISC_AFC])
            afc_irq <= 1'b1;
        else if (ana_cycle_start)
            afc_irq <= 1'b0;
    end

    // Purpose: assemble the misc status word.
    always_comb begin
        misc_stat             = '0;
        misc_stat[MISC_AFC]   = afc_stat;
        misc_stat[MISC_INTR]  = intr_stat;
        misc_stat[MISC_GLAST] = glast_stat;
    end

    // Purpose: register read multiplexer.
    always_comb begin
        rd_mux = '0;
        case (rd_addr)
            A_CFG:     rd_mux = cfg_q;
            A_ST_ANA:  rd_mux = ana_stat;
            A_ST_FAN:  rd_mux = DW'(fan_stat);
            A_ST_GPIO: rd_mux = gpio_stat;
            A_ST_MISC: rd_mux = misc_stat;
            A_MK_ANA:  rd_mux = mask_ana;
            A_MK_FAN:  rd_mux = mask_fan;
            A_MK_GPIO: rd_mux = mask_gpio;
            A_MK_MISC: rd_mux = mask_misc;
            A_POL_LO:  rd_mux = pol_lo;
            A_POL_HI:  rd_mux = DW'(pol_hi);
            default: begin
                for (int j = 0; j < NUM_FAN; j++)
                    if (rd_addr == (A_FAN_LIM + RA_W'(j)))
                        rd_mux = fan_lim[j];
            end
        endcase
    end

    // Purpose: register the read data when a read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

    // Purpose: combine the sources and apply the enable and clear bits.
    always_comb
        int_on = cfg_q[CFG_EN] && !cfg_q[CFG_CLR]
              && (ana_irq || fan_irq || afc_irq || level_any);

    // Purpose: registered active-low interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_n <= 1'b1;
        else
            int_n <= !int_on;
    end

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CFG_EN] |=> int_n);

    p_clear_bit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_CLR] |=> int_n);

    p_primary_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && fan_set == '0 && ana_set == '0) |=> (fan_stat == '0 && ana_stat == '0));

    p_afc_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CFG_AFC] |=> !$rose(afc_stat));

    p_level_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CFG_EN] && !cfg_q[CFG_CLR] && level_any) |=> !int_n);

endmodule

// File: tb/test_hwmon_irq_ctrl.sv
`timescale 1ns/1ps
module test_hwmon_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic [7:0] ana_set = '0;
    logic       ana_cycle_start = 1'b0, fan_cycle_start = 1'b0;
    logic       fan_meas_vld = 1'b0;
    logic [2:0] fan_meas_idx = '0;
    logic [7:0] fan_meas_cnt = '0;
    logic [8:0] gpio_in = '0;
    logic       intrusion = 1'b0, afc_event = 1'b0, alert_resp_hit = 1'b0;
    logic       int_n;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    hwmon_irq_ctrl #(.DW(8), .NUM_FAN(8)) i_hwmon_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ana_set(ana_set),
        .ana_cycle_start(ana_cycle_start), .fan_meas_vld(fan_meas_vld),
        .fan_meas_idx(fan_meas_idx), .fan_meas_cnt(fan_meas_cnt),
        .fan_cycle_start(fan_cycle_start), .gpio_in(gpio_in), .intrusion(intrusion),
        .afc_event(afc_event), .alert_resp_hit(alert_resp_hit), .int_n(int_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a; step(); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic ana_pulse(input logic [7:0] v);
        ana_set = v; step(); ana_set = '0;
    endtask

    task automatic fan_meas(input logic [2:0] i, input logic [7:0] c);
        fan_meas_vld = 1'b1; fan_meas_idx = i; fan_meas_cnt = c; step(); fan_meas_vld = 1'b0;
    endtask

    task automatic pulse_acyc(); ana_cycle_start = 1'b1; step(); ana_cycle_start = 1'b0; endtask
    task automatic pulse_fcyc(); fan_cycle_start = 1'b1; step(); fan_cycle_start = 1'b0; endtask
    task automatic pulse_ack();  alert_resp_hit = 1'b1; step(); alert_resp_hit = 1'b0; endtask
    task automatic pulse_afc();  afc_event = 1'b1; step(); afc_event = 1'b0; endtask

    function automatic logic [8:0] lvl(input logic [8:0] pin, input logic [8:0] pol);
        return pin ^ ~pol;
    endfunction

    function automatic logic exp_int_n(input logic [8:0] l, input logic intr,
                                       input logic [7:0] mg, input logic [7:0] mm);
        return !((|(l[7:0] & ~mg)) | (l[8] & ~mm[7]) | (intr & ~mm[6]));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] lim [8];
        logic [7:0] fstat;
        void'($urandom(32'd2024));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 int_n", int_n, 1);
        check("R1 rd_data", rd_data, 0);
        rd(5'd0, d);  check("R1 cfg", d, 8'h00);
        rd(5'd2, d);  check("R1 fan status", d, 8'h00);
        rd(5'd4, d);  check("R1 misc status", d, 8'h00);
        rd(5'd7, d);  check("R1 gpio mask", d, 8'h00);
        rd(5'd9, d);  check("R1 pol lo", d, 8'hFF);
        rd(5'd10, d); check("R1 pol hi", d, 8'h01);
        rd(5'd23, d); check("R1 fan7 limit", d, 8'hFF);
        rd(5'd1, d);  check("R1 analog status", d, 8'h00);

        // R2 disabled: event latches but no interrupt
        pulse_acyc();
        ana_pulse(8'h08); step();
        check("R2 disabled int_n", int_n, 1);
        rd(5'd1, d); check("R3 status recorded while disabled", d, 8'h08);

        // R7 disarmed by the read above
        wr(5'd0, 8'h02);
        ana_pulse(8'h01); step();
        check("R7 disarmed analog", int_n, 1);
        pulse_acyc();
        ana_pulse(8'h01); step();
        check("R3 analog interrupt", int_n, 0);
        rd(5'd1, d); check("R5 read returns pre-clear", d, 8'h01);
        step();
        check("R6 read clears int", int_n, 1);
        rd(5'd1, d); check("R5 analog cleared", d, 8'h00);

        // R4 fan boundary and clear paths
        pulse_fcyc();
        wr(5'd18, 8'd100);
        rd(5'd18, d); check("R11 limit readback", d, 8'd100);
        fan_meas(3'd2, 8'd100); step();
        check("R4 equal count no int", int_n, 1);
        rd(5'd2, d); check("R4 equal count no status", d, 8'h00);
        fan_meas(3'd2, 8'd101); step();
        check("R4 over limit int", int_n, 0);
        pulse_ack(); step();
        check("R6 ack clears int", int_n, 1);
        rd(5'd2, d); check("R6 ack keeps status", d, 8'h04);
        fan_meas(3'd2, 8'd200); step();
        check("R7 fan disarmed", int_n, 1);
        pulse_acyc();
        fan_meas(3'd2, 8'd200); step();
        check("R7 analog cycle does not arm fan", int_n, 1);
        pulse_fcyc();
        fan_meas(3'd2, 8'd200); step();
        check("R7 fan rearmed", int_n, 0);
        wr(5'd0, 8'h06); step();
        check("R2 clear bit forces high", int_n, 1);
        wr(5'd0, 8'h02); step();
        check("R6 latch gone after clear bit", int_n, 1);

        // R9 mask
        wr(5'd5, 8'h01);
        pulse_acyc();
        ana_pulse(8'h01); step();
        check("R9 masked analog no int", int_n, 1);
        ana_pulse(8'h02); step();
        check("R9 unmasked analog int", int_n, 0);
        rd(5'd1, d); check("R9 masked bit still recorded", d, 8'h03);
        rd(5'd2, d); check("R5 fan cleared by primary read", d, 8'h00);
        wr(5'd5, 8'h00);
        step();
        check("R6 int high after read", int_n, 1);

        // R8/R9 random level patterns
        for (int it = 0; it < 40; it++) begin
            logic [8:0] pol, pin;
            logic [7:0] mg, mm;
            logic intr;
            pol = 9'($urandom); pin = 9'($urandom);
            mg = (it < 4) ? 8'h00 : 8'($urandom);
            mm = (it < 4) ? 8'h00 : 8'($urandom);
            intr = 1'($urandom);
            wr(5'd9, pol[7:0]); wr(5'd10, {7'd0, pol[8]});
            wr(5'd7, mg); wr(5'd8, mm);
            gpio_in = pin; intrusion = intr; step();
            check("R8 level int_n", int_n, exp_int_n(lvl(pin, pol), intr, mg, mm));
            rd(5'd3, d); check("R8 gpio status", d, lvl(pin, pol) & 9'h0FF);
            rd(5'd4, d); check("R8 misc status", d, {lvl(pin, pol)[8], intr, 6'd0});
        end
        wr(5'd7, 8'h00); wr(5'd8, 8'h00);
        wr(5'd9, 8'hFF); wr(5'd10, 8'h01);
        gpio_in = 9'h001; intrusion = 1'b0; step();
        pulse_ack(); rd(5'd1, d); step();
        check("R8 level survives clears", int_n, 0);
        rd(5'd3, d); check("R8 gpio status after clears", d, 8'h01);
        gpio_in = 9'h000; step(); step();
        check("R8 level removed", int_n, 1);

        // R4 random fan measurements
        for (int f = 0; f < 8; f++) begin
            lim[f] = 8'($urandom);
            wr(5'(16 + f), lim[f]);
        end
        fstat = '0;
        for (int it = 0; it < 60; it++) begin
            logic [2:0] i;
            logic [7:0] c;
            i = 3'($urandom);
            c = (it % 4 == 0) ? lim[i] : 8'($urandom);
            fan_meas(i, c);
            if (c > lim[i]) fstat[i] = 1'b1;
            if (it % 6 == 5) begin
                rd(5'd2, d); check("R4 random fan status", d, fstat);
            end
        end
        rd(5'd1, d);
        rd(5'd2, d); check("R5 fan status after primary read", d, 8'h00);
        step();

        // R10 fan-control one-shot
        pulse_afc(); step();
        check("R10 afc disabled no int", int_n, 1);
        rd(5'd4, d); check("R10 afc disabled no status", d, 8'h00);
        wr(5'd0, 8'h0A);
        pulse_afc(); step();
        check("R10 afc int", int_n, 0);
        rd(5'd4, d); check("R10 afc status", d, 8'h10);
        pulse_ack(); step();
        check("R10 afc cleared", int_n, 1);
        step(); step();
        check("R10 afc not reasserted", int_n, 1);
        rd(5'd4, d); check("R10 status kept after ack", d, 8'h10);
        pulse_acyc();
        rd(5'd4, d); check("R10 status cleared by cycle", d, 8'h00);
        pulse_afc(); step();
        check("R10 afc int again", int_n, 0);
        pulse_acyc(); step();
        check("R10 cycle ends one-shot", int_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule